// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit resolves one source operand for a small processor datapath. On a start strobe it takes a four-bit mode code, a short address field, a register number, the current program counter and the current stack pointer. From these it forms an effective address, reads memory zero, one or two times through one shared single-port read interface, and returns the operand together with the effective address it used.

There are eight defined modes, each with a fixed number of memory reads. Immediate and register modes need no memory access. Direct, register indirect, displacement, PC-relative and stack modes need one read. Indirect mode needs two reads, one after the other. A combinational register-file read port supplies register contents. A request on the memory side is held until the memory answers with a valid response, so stalls of any length are tolerated. The unit takes one request at a time. Start strobes that arrive while it is working are dropped.

Top module: `opf_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the address field zero-extended to the data width as the operand, reports effective address 0, makes no memory request, and raises done two cycles after the accepted start.
- R2: Mode code 1 (direct) uses the zero-extended address field as the effective address and returns the word read there with exactly one memory read.
- R3: Mode code 2 (indirect) first reads at the zero-extended address field, takes the low address-width bits of that word as the effective address, and reads again there. Exactly two reads are made, in that order.
- R4: Mode code 3 (register) returns the full contents of the selected register, reports effective address 0 and makes no memory request.
- R5: Mode code 4 (register indirect) uses the low address-width bits of the selected register as the effective address and makes one read.
- R6: Mode code 5 (displacement) uses the zero-extended address field plus the low bits of the selected register, taken modulo 2^AW, as the effective address.
- R7: Mode code 6 (PC-relative) uses the program counter plus the address field as the effective address, modulo 2^AW. The field is sign-extended when SIGNED_REL is 1.
- R8: Mode code 7 (stack) uses the stack-pointer input captured at start as the effective address and makes one read.
- R9: The memory request is first raised the cycle after the evaluation cycle. It stays high with a stable address until the cycle in which the valid response arrives.
- R10: Done is a one-cycle pulse in the cycle after the final read response, with the operand and effective address valid in that cycle. Mode codes 8 to 15 instead raise a one-cycle error pulse two cycles after start, with no done and no memory request.
- R11: A start strobe seen while busy is high is ignored. Busy is high from the cycle after an accepted start until the done or error cycle.
- R12: While reset is asserted, done, error, busy and the memory request are low, and the operand and effective address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| mode_i | input | 4 | Addressing mode code |
| fld_i | input | FW | Address field of the instruction |
| rsel_i | input | RW | Register number |
| pc_i | input | AW | Program counter |
| sp_i | input | AW | Stack pointer |
| rf_addr_o | output | RW | Register-file read address |
| rf_data_i | input | DW | Register-file read data, same cycle |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data |
| mem_rvalid_i | input | 1 | Memory response valid |
| operand_o | output | DW | Fetched operand |
| eff_addr_o | output | AW | Effective address used |
| done_o | output | 1 | Operand valid pulse |
| err_o | output | 1 | Undefined mode pulse |
| busy_o | output | 1 | Request in progress |

## Verification
Every one of the sixteen mode codes is applied, first against a memory that always answers after one cycle and then against one that inserts stall cycles. The stalled run separates correct request holding from a unit that drops or re-issues its request. Register values whose low byte is near the top of the address range, and relative offsets that are negative or that push the sum past the top of the range, show whether sign extension and address wrap-around are correct. Start strobes held over several cycles, with the mode and field inputs changed right after they are captured, show whether new requests are refused while busy and whether the captured values are used throughout.

// File: rtl/opf_pkg.sv
package opf_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      M_IMM  = 4'd0,
      M_DIR  = 4'd1,
      M_IND  = 4'd2,
      M_REG  = 4'd3,
      M_RIND = 4'd4,
      M_DISP = 4'd5,
      M_REL  = 4'd6,
      M_STK  = 4'd7
   } mode_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_EVAL,
      S_PTR,
      S_READ
   } state_e;

endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
   import opf_pkg::*;
#(
   parameter int AW         = 8,
   parameter int DW         = 16,
   parameter int FW         = 6,
   parameter bit SIGNED_REL = 1'b1
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [FW-1:0]     fld,
   input  logic [DW-1:0]     rf_val,
   input  logic [AW-1:0]     pc,
   input  logic [AW-1:0]     sp,
   output logic [AW-1:0]     ea,
   output logic [1:0]        n_acc,
   output logic              defined,
   output logic [DW-1:0]     nomem_val
);

   localparam int PAD_A = AW - FW;
   localparam int PAD_D = DW - FW;

   logic [AW-1:0] fld_a;
   logic [DW-1:0] fld_d;
   logic [AW-1:0] rel_off;
   logic [AW-1:0] reg_a;

   assign fld_a = {{PAD_A{1'b0}}, fld};
   assign fld_d = {{PAD_D{1'b0}}, fld};
   assign reg_a = rf_val[AW-1:0];

   generate
      if (SIGNED_REL) begin : g_rel_sext
         assign rel_off = {{PAD_A{fld[FW-1]}}, fld};
      end else begin : g_rel_zext
         assign rel_off = fld_a;
      end
   endgenerate

   always_comb begin
      ea        = '0;
      n_acc     = 2'd0;
      defined   = 1'b1;
      nomem_val = '0;
      case (mode)
         M_IMM: begin
            nomem_val = fld_d;
         end
         M_DIR: begin
            ea    = fld_a;
            n_acc = 2'd1;
         end
         M_IND: begin
            ea    = fld_a;
            n_acc = 2'd2;
         end
         M_REG: begin
            nomem_val = rf_val;
         end
         M_RIND: begin
            ea    = reg_a;
            n_acc = 2'd1;
         end
         M_DISP: begin
            ea    = fld_a + reg_a;
            n_acc = 2'd1;
         end
         M_REL: begin
            ea    = pc + rel_off;
            n_acc = 2'd1;
         end
         M_STK: begin
            ea    = sp;
            n_acc = 2'd1;
         end
         default: begin
            defined = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
   import opf_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16,
   parameter int FW = 6,
   parameter int RW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [FW-1:0]     fld_i,
   input  logic [RW-1:0]     rsel_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [AW-1:0]     sp_i,
   output logic [MODE_W-1:0] mode_q,
   output logic [FW-1:0]     fld_q,
   output logic [RW-1:0]     rsel_q,
   output logic [AW-1:0]     pc_q,
   output logic [AW-1:0]     sp_q,
   input  logic [AW-1:0]     ea,
   input  logic [1:0]        n_acc,
   input  logic              defined,
   input  logic [DW-1:0]     nomem_val,
   input  logic              mem_rvalid,
   input  logic [DW-1:0]     mem_rdata,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     operand,
   output logic [AW-1:0]     eff_addr,
   output logic              done,
   output logic              err,
   output logic              busy
);

   state_e        state;
   logic [AW-1:0] ea_q;

   assign mem_req  = (state == S_PTR) || (state == S_READ);
   assign mem_addr = ea_q;
   assign busy     = (state != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         mode_q   <= '0;
         fld_q    <= '0;
         rsel_q   <= '0;
         pc_q     <= '0;
         sp_q     <= '0;
         ea_q     <= '0;
         operand  <= '0;
         eff_addr <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  mode_q <= mode_i;
                  fld_q  <= fld_i;
                  rsel_q <= rsel_i;
                  pc_q   <= pc_i;
                  sp_q   <= sp_i;
                  state  <= S_EVAL;
               end
            end
            S_EVAL: begin
               if (!defined) begin
                  err   <= 1'b1;
                  state <= S_IDLE;
               end else if (n_acc == 2'd0) begin
                  operand  <= nomem_val;
                  eff_addr <= '0;
                  done     <= 1'b1;
                  state    <= S_IDLE;
               end else begin
                  ea_q  <= ea;
                  state <= (n_acc == 2'd2) ? S_PTR : S_READ;
               end
            end
            S_PTR: begin
               if (mem_rvalid) begin
                  ea_q  <= mem_rdata[AW-1:0];
                  state <= S_READ;
               end
            end
            S_READ: begin
               if (mem_rvalid) begin
                  operand  <= mem_rdata;
                  eff_addr <= ea_q;
                  done     <= 1'b1;
                  state    <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!done && !mem_req)); // R10
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(mode_q) && $stable(fld_q))); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R11

endmodule

// File: rtl/opf_unit.sv
module opf_unit
   import opf_pkg::*;
#(
   parameter int AW         = 8,
   parameter int DW         = 16,
   parameter int FW         = 6,
   parameter int RW         = 3,
   parameter bit SIGNED_REL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [FW-1:0]     fld_i,
   input  logic [RW-1:0]     rsel_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [AW-1:0]     sp_i,
   output logic [RW-1:0]     rf_addr_o,
   input  logic [DW-1:0]     rf_data_i,
   output logic              mem_req_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic [DW-1:0]     mem_rdata_i,
   input  logic              mem_rvalid_i,
   output logic [DW-1:0]     operand_o,
   output logic [AW-1:0]     eff_addr_o,
   output logic              done_o,
   output logic              err_o,
   output logic              busy_o
);

   generate
      if (FW < 2 || FW >= AW) begin : g_bad_fw
         $error("opf_unit: FW must be at least 2 and below AW");
      end
      if (DW < AW) begin : g_bad_dw
         $error("opf_unit: DW must not be below AW");
      end
      if (RW < 1) begin : g_bad_rw
         $error("opf_unit: RW must be at least 1");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic [FW-1:0]     fld_q;
   logic [RW-1:0]     rsel_q;
   logic [AW-1:0]     pc_q;
   logic [AW-1:0]     sp_q;
   logic [AW-1:0]     ea;
   logic [1:0]        n_acc;
   logic              defined;
   logic [DW-1:0]     nomem_val;

   assign rf_addr_o = rsel_q;

   opf_ea_calc #(
      .AW(AW), .DW(DW), .FW(FW), .SIGNED_REL(SIGNED_REL)
   ) u_ea (
      .mode      (mode_q),
      .fld       (fld_q),
      .rf_val    (rf_data_i),
      .pc        (pc_q),
      .sp        (sp_q),
      .ea        (ea),
      .n_acc     (n_acc),
      .defined   (defined),
      .nomem_val (nomem_val)
   );

   opf_ctrl #(
      .AW(AW), .DW(DW), .FW(FW), .RW(RW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .mode_i     (mode_i),
      .fld_i      (fld_i),
      .rsel_i     (rsel_i),
      .pc_i       (pc_i),
      .sp_i       (sp_i),
      .mode_q     (mode_q),
      .fld_q      (fld_q),
      .rsel_q     (rsel_q),
      .pc_q       (pc_q),
      .sp_q       (sp_q),
      .ea         (ea),
      .n_acc      (n_acc),
      .defined    (defined),
      .nomem_val  (nomem_val),
      .mem_rvalid (mem_rvalid_i),
      .mem_rdata  (mem_rdata_i),
      .mem_req    (mem_req_o),
      .mem_addr   (mem_addr_o),
      .operand    (operand_o),
      .eff_addr   (eff_addr_o),
      .done       (done_o),
      .err        (err_o),
      .busy       (busy_o)
   );

endmodule

// File: tb/opf_unit_bench.sv
`timescale 1ns/1ps
module opf_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int FW = 6;
   localparam int RW = 3;
   localparam int WATCHDOG = 50000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [3:0]    mode_i = '0;
   logic [FW-1:0] fld_i = '0;
   logic [RW-1:0] rsel_i = '0;
   logic [AW-1:0] pc_i = '0;
   logic [AW-1:0] sp_i = '0;
   logic [RW-1:0] rf_addr_o;
   logic [DW-1:0] rf_data_i;
   logic          mem_req_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_rdata_i = '0;
   logic          mem_rvalid_i = 1'b0;
   logic [DW-1:0] operand_o;
   logic [AW-1:0] eff_addr_o;
   logic          done_o, err_o, busy_o;

   logic [DW-1:0] mem  [1<<AW];
   logic [DW-1:0] regs [1<<RW];
   bit            stall_en = 1'b0;
   int            mem_cyc = 0;

   int  nvec = 0;
   int  nfail = 0;
   int  cyc = 0;
   bit  reported = 1'b0;

   // reference model state
   int    phase = 0;
   int    exp_q[$];
   int    exp_op = 0;
   int    exp_ea = 0;
   bit    fire_done = 1'b0;
   bit    fire_err = 1'b0;
   string cur_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   opf_unit #(.AW(AW), .DW(DW), .FW(FW), .RW(RW), .SIGNED_REL(1'b1)) u_opf_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .fld_i(fld_i), .rsel_i(rsel_i), .pc_i(pc_i), .sp_i(sp_i),
      .rf_addr_o(rf_addr_o), .rf_data_i(rf_data_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
      .operand_o(operand_o), .eff_addr_o(eff_addr_o),
      .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
   );

   assign rf_data_i = regs[rf_addr_o];

   // memory: one response per request, one cycle latency, optional stalls
   always @(posedge clk) begin
      mem_cyc <= mem_cyc + 1;
      if (mem_req_o && !mem_rvalid_i && !(stall_en && (mem_cyc % 3 != 0))) begin
         mem_rvalid_i <= 1'b1;
         mem_rdata_i  <= mem[mem_addr_o];
      end else begin
         mem_rvalid_i <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      end
   endtask

   function automatic string mode_tag(input int m);
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         7: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic accept();
      int m, a, rv, sa, p;
      m  = int'(mode_i);
      a  = int'(fld_i);
      rv = int'(regs[rsel_i]);
      exp_q.delete();
      exp_ea = 0;
      exp_op = 0;
      cur_tag = mode_tag(m);
      case (m)
         0: exp_op = a;
         1: begin exp_ea = a; exp_q.push_back(a); end
         2: begin
            p = int'(mem[a]) & 255;
            exp_ea = p;
            exp_q.push_back(a);
            exp_q.push_back(p);
         end
         3: exp_op = rv;
         4: begin exp_ea = rv & 255; exp_q.push_back(exp_ea); end
         5: begin exp_ea = (a + rv) & 255; exp_q.push_back(exp_ea); end
         6: begin
            sa = (a >= 32) ? a - 64 : a;
            exp_ea = (int'(pc_i) + sa) & 255;
            exp_q.push_back(exp_ea);
         end
         7: begin exp_ea = int'(sp_i); exp_q.push_back(exp_ea); end
         default: ;
      endcase
      if (m <= 7 && m != 0 && m != 3) exp_op = int'(mem[exp_ea]);
      phase = (m > 7) ? 3 : 1;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         nfail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
         report();
         $finish;
      end
      if (!rst_n) begin
         // R12 reset state
         chk(done_o == 1'b0, "R12", "done in reset", done_o, 0);
         chk(err_o == 1'b0, "R12", "err in reset", err_o, 0);
         chk(busy_o == 1'b0, "R12", "busy in reset", busy_o, 0);
         chk(mem_req_o == 1'b0, "R12", "req in reset", mem_req_o, 0);
         chk(operand_o == '0 && eff_addr_o == '0, "R12", "data in reset",
             {operand_o, eff_addr_o}, 0);
         phase = 0;
         fire_done = 0;
         fire_err = 0;
      end else begin
         chk(done_o == fire_done, "R10", "done timing", done_o, fire_done);
         chk(err_o == fire_err, "R10", "err timing", err_o, fire_err);
         chk(busy_o == (phase != 0), "R11", "busy", busy_o, phase != 0);
         chk(mem_req_o == (phase == 2), "R9", "mem_req", mem_req_o, phase == 2);
         if (phase == 2 && exp_q.size() > 0)
            chk(mem_addr_o == AW'(exp_q[0]), "R9", "mem_addr", mem_addr_o, exp_q[0]);
         if (fire_done) begin
            chk(operand_o == DW'(exp_op), cur_tag, "operand", operand_o, exp_op);
            chk(eff_addr_o == AW'(exp_ea), cur_tag, "eff_addr", eff_addr_o, exp_ea);
         end
         if (start_i && phase != 0)
            chk(1'b1, "R11", "start ignored while busy", 0, 0);
         // advance model
         fire_done = 0;
         fire_err = 0;
         case (phase)
            0: if (start_i) accept();
            1: begin
               if (exp_q.size() == 0) begin fire_done = 1; phase = 0; end
               else phase = 2;
            end
            2: if (mem_rvalid_i) begin
               void'(exp_q.pop_front());
               if (exp_q.size() == 0) begin fire_done = 1; phase = 0; end
            end
            3: begin fire_err = 1; phase = 0; end
            default: phase = 0;
         endcase
      end
   end

   task automatic run(input int m, input int a, input int r, input int pcv,
                      input int spv, input int hold);
      @(posedge clk); #1;
      mode_i  = 4'(m);
      fld_i   = FW'(a);
      rsel_i  = RW'(r);
      pc_i    = AW'(pcv);
      sp_i    = AW'(spv);
      start_i = 1'b1;
      for (int h = 1; h < hold; h++) begin
         @(posedge clk); #1;
      end
      @(posedge clk); #1;
      start_i = 1'b0;
      mode_i  = ~mode_i;
      fld_i   = ~fld_i;
      rsel_i  = ~rsel_i;
      pc_i    = ~pc_i;
      sp_i    = ~sp_i;
      for (int g = 0; g < 200 && busy_o; g++) begin
         @(posedge clk); #1;
      end
      @(posedge clk); #1;
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++)
         mem[i] = DW'((i * 40503 + 4660) ^ (i << 9));
      for (int i = 0; i < (1 << RW); i++)
         regs[i] = DW'(i * 16'h1111 + 16'h0203);
      regs[7] = 16'hABF0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // no stalls: each mode once, plus corner cases
      run(0, 6'h2A, 0, 8'h10, 8'h20, 1);   // R1
      run(1, 6'h11, 0, 8'h10, 8'h20, 1);   // R2
      run(2, 6'h05, 0, 8'h10, 8'h20, 1);   // R3
      run(3, 0, 3, 8'h10, 8'h20, 1);       // R4
      run(4, 0, 5, 8'h10, 8'h20, 1);       // R5
      run(5, 6'h3F, 7, 8'h10, 8'h20, 1);   // R6 wrap past top
      run(6, 6'h3E, 0, 8'h05, 8'h20, 1);   // R7 negative offset
      run(6, 6'h05, 0, 8'hFE, 8'h20, 1);   // R7 wrap
      run(7, 0, 0, 8'h10, 8'hC3, 1);       // R8
      run(9, 6'h01, 0, 8'h10, 8'h20, 1);   // R10 undefined
      run(15, 6'h01, 0, 8'h10, 8'h20, 1);  // R10 undefined
      run(2, 6'h21, 2, 8'h10, 8'h20, 4);   // R11 start held while busy
      run(0, 6'h15, 0, 8'h10, 8'h20, 3);   // R11 start held across done
      // stalled memory: all codes
      stall_en = 1'b1;
      for (int m = 0; m < 16; m++)
         run(m, (m * 7 + 3) & 63, m & 7, (m * 19) & 255, (255 - m * 5) & 255, 1 + (m % 3));
      run(3, 0, 7, 8'h00, 8'h00, 1);       // R4 full register width
      repeat (3) @(posedge clk);
      report();
      $finish;
   end

endmodule